// File: doc/BRIEF.md
# Bus Write FIFO Status Sequencer

This block models the visible busy flags of a write FIFO that sits on a peripheral bus. It stores no data. Each one-cycle write strobe from the host side starts a timed sequence, or stretches a sequence already running. Three flags describe the sequence: an input-stage flag that rises on the write itself, a middle-stage flag that follows later, and an output-stage flag that follows after that. Each flag drops after its own hold interval.

The flags are placed into a status word that software-facing logic elsewhere reads. The input-stage flag is bit 5, the middle-stage flag is bit 4 and the output-stage flag is bit 0. Every other bit is zero. Each flag edge has its own down-counter with a valid bit, and all counters tick once per clock. A write adds to any hold timer that is still running. It loads any timer that is idle, and it leaves a pending rise timer alone. So a burst of writes keeps the flags high for longer without moving the moments at which they first rise.

All intervals are given in clock cycles and set by parameters. The defaults are 60 cycles of input hold, a middle rise at 60 with a hold of 160, and an output rise at 120 with a hold of 420.

Top module: `fifo_stat_seq`

## Requirements
- R1: On the clock edge that samples `wr_stb` high, status bit 5 becomes 1. After a lone write it stays 1 for exactly 60 cycles, so it reads 0 from the 60th edge after the write onwards.
- R2: Status bit 4 becomes 1 on the 60th edge after a write that finds the bit-4 rise timer idle. It becomes 0 on the 160th edge after it rose.
- R3: Status bit 0 becomes 1 on the 120th edge after a write that finds the bit-0 rise timer idle. It becomes 0 on the 420th edge after it rose.
- R4: A write that arrives while a flag's fall timer is running adds that flag's hold (60, 160 or 420 cycles) to the time remaining. A rise that is already pending keeps its original edge.
- R5: A write that arrives after a flag's fall timer has expired reloads that timer. For bits 4 and 0 the new fall is counted from the newly scheduled rise (60+160 and 120+420 edges after the write). For bit 5 it is counted from the write (60 edges).
- R6: During and after reset the status word reads 0, and it stays 0 until the first write.
- R7: A write that lands on the very edge where a flag's fall timer would expire extends that timer instead, so the flag does not drop on that edge.
- R8: Status bits 1 to 3 and 6 to 31 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; every timer ticks on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; idles all timers and clears the flags |
| wr_stb | input | 1 | One-cycle pulse for each bus write from the host side |
| status_word | output | 32 | Flags at bit 5 (input stage), bit 4 (middle) and bit 0 (output); other bits zero |

## Verification
The two functions that can meet on one edge are the expiry of a fall timer and a new write that extends that same timer. The bench provokes this by placing a second strobe exactly 60 edges after the first, which is the edge where the input-stage flag would otherwise drop. On that same edge the middle-stage rise timer fires and ignores the write. The result is judged at the ports: bit 5 must still read 1 after that edge and must fall 60 edges later, bit 4 must rise on schedule, and both hold timers must end at their extended edges.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

   // Status word bit positions (decoded by the reading side)
   localparam int STAT_IN_BIT  = 5;
   localparam int STAT_MID_BIT = 4;
   localparam int STAT_OUT_BIT = 0;

   // A stage either rises on the write itself or after its own delay
   typedef enum logic {
      STG_IMMEDIATE = 1'b0,
      STG_DELAYED   = 1'b1
   } stage_kind_e;

   // Saturating add used for every count that can grow on extension
   function automatic logic [31:0] fsq_sat_add(input logic [31:0] a,
                                               input logic [31:0] b,
                                               input logic [31:0] cap);
      logic [32:0] s;
      s = {1'b0, a} + {1'b0, b};
      if (s > {1'b0, cap}) return cap;
      return s[31:0];
   endfunction

endpackage

// File: rtl/fsq_countdown.sv
module fsq_countdown #(
   parameter int CNT_W  = 16,
   parameter bit EXTEND = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             ext_i,
   input  logic [CNT_W-1:0] ext_val_i,
   output logic             valid_o,
   output logic [CNT_W-1:0] count_o,
   output logic             fire_o
);
   import fsq_pkg::*;

   localparam logic [31:0] CNT_CAP = 32'((64'd1 << CNT_W) - 64'd1);

   logic             valid_q;
   logic [CNT_W-1:0] count_q;
   logic             do_ext;
   logic [CNT_W-1:0] ext_sum;

   // Extension applies only to a running timer of an extendable kind
   assign do_ext  = EXTEND && ext_i && valid_q;
   assign ext_sum = CNT_W'(fsq_sat_add(32'(count_q) - 32'd1, 32'(ext_val_i), CNT_CAP));
   assign fire_o  = valid_q && (count_q == CNT_W'(1)) && !do_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         count_q <= '0;
      end else if (!valid_q) begin
         if (load_i) begin
            valid_q <= 1'b1;
            count_q <= load_val_i;
         end
      end else if (do_ext) begin
         count_q <= ext_sum;
      end else if (count_q == CNT_W'(1)) begin
         valid_q <= 1'b0;
         count_q <= '0;
      end else begin
         count_q <= count_q - CNT_W'(1);
      end
   end

   assign valid_o = valid_q;
   assign count_o = count_q;

   AST_EXTEND_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (EXTEND && valid_q && ext_i) |=> (valid_q && count_q >= $past(count_q))) else $error("extend shrank timer"); // R4

   AST_LOAD_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_q && load_i) |=> (valid_q && count_q == $past(load_val_i))) else $error("idle timer not loaded"); // R5

   AST_FIRE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> !valid_q) else $error("timer stayed valid after firing"); // R5

endmodule

// File: rtl/fsq_flag.sv
module fsq_flag #(
   parameter int                  CNT_W = 16,
   parameter fsq_pkg::stage_kind_e KIND = fsq_pkg::STG_DELAYED,
   parameter int                  RISE  = 60,
   parameter int                  HOLD  = 160
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   output logic flag_o
);
   import fsq_pkg::*;

   localparam logic [31:0] CNT_CAP = 32'((64'd1 << CNT_W) - 64'd1);

   logic             set_evt;
   logic [CNT_W-1:0] fall_load;
   logic             fall_valid;
   logic [CNT_W-1:0] fall_cnt;
   logic             fall_fire;
   logic             flag_q;

   initial begin
      assert (HOLD >= 1) else $error("hold must be at least one cycle");
   end

   generate
      if (KIND == STG_IMMEDIATE) begin : g_now
         // Rises on the write edge; fall counted from the write
         assign set_evt   = wr_i;
         assign fall_load = CNT_W'(HOLD);
      end else begin : g_late
         logic             rise_valid;
         logic [CNT_W-1:0] rise_cnt;
         logic             rise_fire;
         logic [CNT_W-1:0] rise_after;

         initial begin
            assert (RISE >= 1) else $error("delayed stage needs a rise delay");
         end

         // Rise timer: loaded only from idle, never extended
         fsq_countdown #(.CNT_W(CNT_W), .EXTEND(1'b0)) u_rise (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (wr_i),
            .load_val_i (CNT_W'(RISE)),
            .ext_i      (1'b0),
            .ext_val_i  ('0),
            .valid_o    (rise_valid),
            .count_o    (rise_cnt),
            .fire_o     (rise_fire)
         );

         // Distance to the rise point as seen after this edge
         assign rise_after = rise_valid ? (rise_cnt - CNT_W'(1)) : CNT_W'(RISE);
         assign fall_load  = CNT_W'(fsq_sat_add(32'(rise_after), 32'(HOLD), CNT_CAP));
         assign set_evt    = rise_fire;
      end
   endgenerate

   fsq_countdown #(.CNT_W(CNT_W), .EXTEND(1'b1)) u_fall (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (wr_i),
      .load_val_i (fall_load),
      .ext_i      (wr_i),
      .ext_val_i  (CNT_W'(HOLD)),
      .valid_o    (fall_valid),
      .count_o    (fall_cnt),
      .fire_o     (fall_fire)
   );

   // Fall takes priority when both edges meet
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (fall_fire) flag_q <= 1'b0;
      else if (set_evt)   flag_q <= 1'b1;
   end

   assign flag_o = flag_q;

   AST_FALL_ENDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      fall_fire |=> !flag_q) else $error("flag survived its fall event"); // R2

   AST_HIGH_NEEDS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q |-> (fall_valid && fall_cnt != '0)) else $error("flag high without pending fall"); // R7

endmodule

// File: rtl/fifo_stat_seq.sv
module fifo_stat_seq #(
   parameter int CNT_W    = 16,
   parameter int STAT_W   = 32,
   parameter int IN_HOLD  = 60,
   parameter int MID_RISE = 60,
   parameter int MID_HOLD = 160,
   parameter int OUT_RISE = 120,
   parameter int OUT_HOLD = 420
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   output logic [STAT_W-1:0] status_word
);
   import fsq_pkg::*;

   localparam int N_STG = 3;
   localparam int STG_POS [N_STG] = '{STAT_IN_BIT, STAT_MID_BIT, STAT_OUT_BIT};
   localparam int STG_RISE[N_STG] = '{0, MID_RISE, OUT_RISE};
   localparam int STG_HOLD[N_STG] = '{IN_HOLD, MID_HOLD, OUT_HOLD};
   localparam longint CNT_CAP = (64'd1 << CNT_W) - 64'd1;

   initial begin
      assert (CNT_W >= 8 && CNT_W <= 31) else $error("CNT_W out of range");
      assert (STAT_W > STAT_IN_BIT) else $error("status word too narrow");
      assert (longint'(MID_RISE) + longint'(MID_HOLD) <= CNT_CAP) else $error("middle stage exceeds counter");
      assert (longint'(OUT_RISE) + longint'(OUT_HOLD) <= CNT_CAP) else $error("output stage exceeds counter");
   end

   logic [N_STG-1:0] flag_w;

   generate
      for (genvar g = 0; g < N_STG; g++) begin : g_stage
         fsq_flag #(
            .CNT_W (CNT_W),
            .KIND  ((g == 0) ? STG_IMMEDIATE : STG_DELAYED),
            .RISE  (STG_RISE[g]),
            .HOLD  (STG_HOLD[g])
         ) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_i   (wr_stb),
            .flag_o (flag_w[g])
         );
      end
   endgenerate

   always_comb begin
      status_word = '0;
      for (int i = 0; i < N_STG; i++) status_word[STG_POS[i]] = flag_w[i];
   end

   AST_IN_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> status_word[STAT_IN_BIT]) else $error("input flag not raised by write"); // R1

endmodule

// File: tb/fifo_stat_seq_tb.sv
module fifo_stat_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [31:0] status_word;

   int n_checks = 0;
   int n_fail   = 0;
   int pos      = 0;
   bit done     = 1'b0;

   localparam int T0 = 10;

   always #4 clk = ~clk;   // 125 MHz

   fifo_stat_seq u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stb      (wr_stb),
      .status_word (status_word)
   );

   task automatic do_reset();
      rst_n  = 1'b0;
      wr_stb = 1'b0;
      repeat (3) @(negedge clk);
      n_checks++;
      if (status_word !== 32'h0) begin
         n_fail++;
         $display("FAIL R6 in reset: actual %h expected %h", status_word, 32'h0);
      end
      rst_n = 1'b1;
      pos   = 0;
   endtask

   task automatic step_to(input int k);
      while (pos < k) begin
         @(negedge clk);
         pos++;
      end
   endtask

   // Strobe sampled by edge k; returns at the negedge after edge k
   task automatic strobe_at(input int k);
      step_to(k - 1);
      wr_stb = 1'b1;
      @(negedge clk);
      pos++;
      wr_stb = 1'b0;
   endtask

   task automatic expect_bit(input int at, input int bitn, input logic exp, input string req);
      step_to(at);
      n_checks++;
      if (status_word[bitn] !== exp) begin
         n_fail++;
         $display("FAIL %s at edge %0d bit %0d: actual %b expected %b", req, at, bitn, status_word[bitn], exp);
      end
   endtask

   task automatic expect_word(input int at, input logic [31:0] exp, input string req);
      step_to(at);
      n_checks++;
      if (status_word !== exp) begin
         n_fail++;
         $display("FAIL %s at edge %0d: actual %h expected %h", req, at, status_word, exp);
      end
   endtask

   task automatic test_reset();   // R6
      do_reset();
      expect_word(0, 32'h0, "R6");
      expect_word(300, 32'h0, "R6");
   endtask

   task automatic test_single();   // R1 R2 R3 R8
      do_reset();
      expect_word(T0 - 1, 32'h0, "R6");
      strobe_at(T0);
      expect_word(T0, 32'h0000_0020, "R1");
      expect_bit(T0 + 59, 5, 1'b1, "R1");
      expect_bit(T0 + 59, 4, 1'b0, "R2");
      expect_bit(T0 + 60, 5, 1'b0, "R1");
      expect_bit(T0 + 60, 4, 1'b1, "R2");
      expect_bit(T0 + 119, 0, 1'b0, "R3");
      expect_bit(T0 + 120, 0, 1'b1, "R3");
      expect_word(T0 + 130, 32'h0000_0011, "R8");
      expect_bit(T0 + 219, 4, 1'b1, "R2");
      expect_bit(T0 + 220, 4, 1'b0, "R2");
      expect_bit(T0 + 539, 0, 1'b1, "R3");
      expect_word(T0 + 540, 32'h0, "R3");
   endtask

   task automatic test_extend();   // R4
      do_reset();
      strobe_at(T0);
      strobe_at(T0 + 30);
      expect_bit(T0 + 59, 4, 1'b0, "R4");
      expect_bit(T0 + 60, 4, 1'b1, "R4");
      expect_bit(T0 + 119, 5, 1'b1, "R4");
      expect_bit(T0 + 119, 0, 1'b0, "R4");
      expect_bit(T0 + 120, 5, 1'b0, "R4");
      expect_bit(T0 + 120, 0, 1'b1, "R4");
      expect_word(T0 + 130, 32'h0000_0011, "R8");
      expect_bit(T0 + 379, 4, 1'b1, "R4");
      expect_bit(T0 + 380, 4, 1'b0, "R4");
      expect_bit(T0 + 959, 0, 1'b1, "R4");
      expect_bit(T0 + 960, 0, 1'b0, "R4");
      // back-to-back burst of three writes
      do_reset();
      strobe_at(T0);
      strobe_at(T0 + 1);
      strobe_at(T0 + 2);
      expect_bit(T0 + 59, 4, 1'b0, "R4");
      expect_bit(T0 + 60, 4, 1'b1, "R4");
      expect_bit(T0 + 179, 5, 1'b1, "R4");
      expect_bit(T0 + 180, 5, 1'b0, "R4");
      expect_bit(T0 + 539, 4, 1'b1, "R4");
      expect_bit(T0 + 540, 4, 1'b0, "R4");
      expect_bit(T0 + 1379, 0, 1'b1, "R4");
      expect_bit(T0 + 1380, 0, 1'b0, "R4");
   endtask

   task automatic test_boundary();   // R7
      do_reset();
      strobe_at(T0);
      strobe_at(T0 + 60);
      expect_bit(T0 + 60, 5, 1'b1, "R7");
      expect_bit(T0 + 60, 4, 1'b1, "R7");
      expect_bit(T0 + 119, 5, 1'b1, "R7");
      expect_bit(T0 + 120, 5, 1'b0, "R7");
      expect_bit(T0 + 379, 4, 1'b1, "R7");
      expect_bit(T0 + 380, 4, 1'b0, "R7");
      expect_bit(T0 + 959, 0, 1'b1, "R7");
      expect_bit(T0 + 960, 0, 1'b0, "R7");
   endtask

   task automatic test_restart();   // R5
      do_reset();
      strobe_at(T0);
      expect_bit(T0 + 220, 4, 1'b0, "R5");
      strobe_at(T0 + 230);
      expect_bit(T0 + 230, 5, 1'b1, "R5");
      expect_bit(T0 + 289, 4, 1'b0, "R5");
      expect_bit(T0 + 289, 5, 1'b1, "R5");
      expect_bit(T0 + 290, 4, 1'b1, "R5");
      expect_bit(T0 + 290, 5, 1'b0, "R5");
      expect_bit(T0 + 449, 4, 1'b1, "R5");
      expect_bit(T0 + 450, 4, 1'b0, "R5");
      expect_bit(T0 + 959, 0, 1'b1, "R5");
      expect_bit(T0 + 960, 0, 1'b0, "R5");
      // fully idle, then a fresh sequence
      expect_word(T0 + 1499, 32'h0, "R5");
      strobe_at(T0 + 1500);
      expect_bit(T0 + 1500, 5, 1'b1, "R5");
      expect_bit(T0 + 1560, 5, 1'b0, "R5");
      expect_bit(T0 + 1560, 4, 1'b1, "R5");
      expect_bit(T0 + 1620, 0, 1'b1, "R5");
      expect_bit(T0 + 1720, 4, 1'b0, "R5");
      expect_word(T0 + 2040, 32'h0, "R5");
   endtask

   initial begin
      test_reset();
      test_single();
      test_extend();
      test_boundary();
      test_restart();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual 100000 cycles expected completion earlier");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule